// File: doc/BRIEF.md
# Scrambled AMI Burst Codec

This block turns a short run of payload bits into a burst of three-level line symbols, and turns such symbols back into bits. The transmit half opens each burst with a single mark that is never scrambled. It then passes a fixed number of payload bits through a self-synchronizing scrambler and sends each scrambled one as a pulse. Pulses alternate in polarity, and each scrambled zero is sent as no pulse. The polarity sequence carries on from one burst to the next. The start mark always takes the polarity opposite to the last pulse of the previous burst.

The receive half treats the first mark that arrives while it is idle as a start mark. It descrambles the fixed number of symbols that follow, using the same polynomial, and flags every pulse whose polarity repeats that of the pulse before it. Both halves step once per line-symbol tick, which is a one-cycle enable in the system clock domain. Framing of payload fields, pulse shaping and the analog line are handled elsewhere.

Top module: `ami_burst_codec`

## Requirements
- R1: After reset, the transmit symbol is zero and busy is low. The receive valid and violation outputs are low, and the scrambler and descrambler states are all zero. The first start mark after reset is positive.
- R2: Symbol encoding is 2'b00 for no pulse, 2'b01 for a positive pulse and 2'b10 for a negative pulse. The transmitter never drives 2'b11, and the receiver treats 2'b11 as no pulse.
- R3: A tick that sees a burst request while the transmitter is idle emits a start mark. Its polarity is opposite to the last pulse sent. The start bit neither passes through nor enters the scrambler.
- R4: Each burst sends exactly PAYLOAD_BITS payload symbols after the start mark, one per tick. tx_take is high on exactly those ticks, and busy drops after the last of them.
- R5: Each scrambled bit equals the payload bit XOR the scrambled bits sent SCR_TAP and SCR_LEN payload positions earlier (5 and 9 by default). The scrambler history persists across bursts.
- R6: A scrambled one is sent as a pulse whose polarity is opposite to the previous pulse, and a scrambled zero is sent as no pulse.
- R7: A burst request raised while a burst is in progress, or on cycles without a tick, starts no burst.
- R8: On every tick with the transmitter idle and no request, the symbol is zero.
- R9: The receiver descrambles the PAYLOAD_BITS symbols that follow a start mark. Each recovered bit is the received bit XOR the received bits SCR_TAP and SCR_LEN positions earlier. rx_valid pulses for one cycle after each such tick.
- R10: rx_bpv pulses for one cycle after a tick whose pulse has the same polarity as the previous received pulse. This includes start marks and pulses that cross a burst boundary. No violation is flagged before the first pulse after reset.
- R11: The transmit symbol changes only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_tick | input | 1 | Transmit line-symbol enable |
| burst_req | input | 1 | Request to start a burst, sampled on ticks |
| tx_bit | input | 1 | Payload bit consumed on ticks where tx_take is high |
| tx_take | output | 1 | Payload bit accepted this cycle |
| tx_busy | output | 1 | Burst in progress |
| tx_sym | output | 2 | Transmit symbol (00 zero, 01 positive, 10 negative) |
| rx_tick | input | 1 | Receive line-symbol enable |
| rx_sym | input | 2 | Received symbol |
| rx_bit | output | 1 | Descrambled payload bit |
| rx_valid | output | 1 | rx_bit holds a new bit |
| rx_bpv | output | 1 | Bipolar violation seen on the last received tick |

## Verification
The bench builds the block with its defaults: 36 payload bits and a nine-stage scrambler tapped at stage five. With these values, an all-zero payload from the reset state gives a burst in which the start mark is the only pulse. Back-to-back bursts exercise scrambler history that reaches past the first nine bits, and polarity that carries across burst edges. Looping the transmit symbols into the receiver checks descrambling against the original payload. Forced receive symbols then provoke violations of both polarities and the unused 2'b11 code.

// File: rtl/ami_pkg.sv
package ami_pkg;
   typedef enum logic [1:0] {
      SYM_ZERO = 2'b00,
      SYM_POS  = 2'b01,
      SYM_NEG  = 2'b10,
      SYM_BAD  = 2'b11
   } sym_e;

   function automatic sym_e pulse_of(input logic neg);
      return neg ? SYM_NEG : SYM_POS;
   endfunction
endpackage

// File: rtl/ami_scrambler.sv
module ami_scrambler #(
   parameter int SCR_LEN    = 9,
   parameter int SCR_TAP    = 5,
   parameter bit DESCRAMBLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic dout
);
   logic [SCR_LEN-1:0] hist;
   logic               line_bit;

   if (SCR_TAP < 1 || SCR_TAP >= SCR_LEN) begin : g_bad_tap
      $error("ami_scrambler: SCR_TAP must lie in 1..SCR_LEN-1");
   end

   assign dout = din ^ hist[SCR_TAP-1] ^ hist[SCR_LEN-1];

   // The history always holds the line-side sequence.
   if (DESCRAMBLE) begin : g_desc
      assign line_bit = din;
   end else begin : g_scr
      assign line_bit = dout;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  hist <= '0;
      else if (en) hist <= {hist[SCR_LEN-2:0], line_bit};
   end
endmodule

// File: rtl/ami_tx_burst.sv
module ami_tx_burst
   import ami_pkg::*;
#(
   parameter int PAYLOAD_BITS = 36,
   parameter int SCR_LEN      = 9,
   parameter int SCR_TAP      = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sym_tick,
   input  logic       burst_req,
   input  logic       tx_bit,
   output logic       tx_take,
   output logic       tx_busy,
   output logic [1:0] tx_sym
);
   localparam int CW = $clog2(PAYLOAD_BITS + 1);

   if (PAYLOAD_BITS < 1) begin : g_bad_len
      $error("ami_tx_burst: PAYLOAD_BITS must be positive");
   end

   logic          busy;
   logic [CW-1:0] left;
   logic          last_neg;
   logic          scr_bit;
   sym_e          sym_q;

   assign tx_take = sym_tick & busy;
   assign tx_busy = busy;
   assign tx_sym  = sym_q;

   ami_scrambler #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP), .DESCRAMBLE(1'b0)) u_scr (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (tx_take),
      .din  (tx_bit),
      .dout (scr_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         left     <= '0;
         last_neg <= 1'b1;
         sym_q    <= SYM_ZERO;
      end else if (sym_tick) begin
         if (busy) begin
            if (scr_bit) begin
               sym_q    <= pulse_of(!last_neg);
               last_neg <= !last_neg;
            end else begin
               sym_q <= SYM_ZERO;
            end
            left <= left - 1'b1;
            if (left == CW'(1)) busy <= 1'b0;
         end else if (burst_req) begin
            sym_q    <= pulse_of(!last_neg);
            last_neg <= !last_neg;
            busy     <= 1'b1;
            left     <= CW'(PAYLOAD_BITS);
         end else begin
            sym_q <= SYM_ZERO;
         end
      end
   end
endmodule

// File: rtl/ami_rx_burst.sv
module ami_rx_burst
   import ami_pkg::*;
#(
   parameter int PAYLOAD_BITS = 36,
   parameter int SCR_LEN      = 9,
   parameter int SCR_TAP      = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_tick,
   input  logic [1:0] rx_sym,
   output logic       rx_bit,
   output logic       rx_valid,
   output logic       rx_bpv
);
   localparam int CW = $clog2(PAYLOAD_BITS + 1);

   logic          busy;
   logic [CW-1:0] left;
   logic          seen_mark;
   logic          prev_neg;
   logic          is_mark;
   logic          is_neg;
   logic          desc_bit;

   assign is_neg  = (rx_sym == SYM_NEG);
   assign is_mark = (rx_sym == SYM_POS) || is_neg;

   ami_scrambler #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP), .DESCRAMBLE(1'b1)) u_desc (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (rx_tick & busy),
      .din  (is_mark),
      .dout (desc_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         left      <= '0;
         seen_mark <= 1'b0;
         prev_neg  <= 1'b0;
         rx_bit    <= 1'b0;
         rx_valid  <= 1'b0;
         rx_bpv    <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         rx_bpv   <= 1'b0;
         if (rx_tick) begin
            if (is_mark) begin
               rx_bpv    <= seen_mark && (is_neg == prev_neg);
               prev_neg  <= is_neg;
               seen_mark <= 1'b1;
            end
            if (busy) begin
               rx_valid <= 1'b1;
               rx_bit   <= desc_bit;
               left     <= left - 1'b1;
               if (left == CW'(1)) busy <= 1'b0;
            end else if (is_mark) begin
               busy <= 1'b1;
               left <= CW'(PAYLOAD_BITS);
            end
         end
      end
   end
endmodule

// File: rtl/ami_burst_codec.sv
module ami_burst_codec #(
   parameter int PAYLOAD_BITS = 36,
   parameter int SCR_LEN      = 9,
   parameter int SCR_TAP      = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sym_tick,
   input  logic       burst_req,
   input  logic       tx_bit,
   output logic       tx_take,
   output logic       tx_busy,
   output logic [1:0] tx_sym,
   input  logic       rx_tick,
   input  logic [1:0] rx_sym,
   output logic       rx_bit,
   output logic       rx_valid,
   output logic       rx_bpv
);
   ami_tx_burst #(.PAYLOAD_BITS(PAYLOAD_BITS), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_tick (sym_tick),
      .burst_req(burst_req),
      .tx_bit   (tx_bit),
      .tx_take  (tx_take),
      .tx_busy  (tx_busy),
      .tx_sym   (tx_sym)
   );

   ami_rx_burst #(.PAYLOAD_BITS(PAYLOAD_BITS), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_tick (rx_tick),
      .rx_sym  (rx_sym),
      .rx_bit  (rx_bit),
      .rx_valid(rx_valid),
      .rx_bpv  (rx_bpv)
   );
endmodule

// File: rtl/ami_burst_codec_chk.sv
module ami_burst_codec_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sym_tick,
   input logic       burst_req,
   input logic       tx_take,
   input logic       tx_busy,
   input logic [1:0] tx_sym,
   input logic       rx_tick,
   input logic       rx_valid,
   input logic       rx_bpv
);
   logic       tick_d;
   logic       have_pulse;
   logic [1:0] last_pulse;
   logic       new_pulse;

   assign new_pulse = tick_d && (tx_sym == 2'b01 || tx_sym == 2'b10);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_d     <= 1'b0;
         have_pulse <= 1'b0;
         last_pulse <= 2'b00;
      end else begin
         tick_d <= sym_tick;
         if (new_pulse) begin
            have_pulse <= 1'b1;
            last_pulse <= tx_sym;
         end
      end
   end

   AST_SYM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sym != 2'b11);                                                   // R2
   AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sym_tick) |-> $stable(tx_sym));                              // R11
   AST_TAKE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> (tx_busy && sym_tick));                                 // R4
   AST_PULSE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (new_pulse && have_pulse) |-> (tx_sym != last_pulse));              // R6
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sym_tick) && !$past(tx_busy) && !$past(burst_req)) |-> (tx_sym == 2'b00)); // R8
   AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(rx_tick));                                       // R9
   AST_BPV_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_bpv |-> $past(rx_tick));                                         // R10
endmodule

bind ami_burst_codec ami_burst_codec_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sym_tick (sym_tick),
   .burst_req(burst_req),
   .tx_take  (tx_take),
   .tx_busy  (tx_busy),
   .tx_sym   (tx_sym),
   .rx_tick  (rx_tick),
   .rx_valid (rx_valid),
   .rx_bpv   (rx_bpv)
);

// File: tb/ami_burst_codec_test.sv
`timescale 1ns/100ps
module ami_burst_codec_test;
   localparam int NB = 36;
   localparam int NV = 5;
   // {payload, request-during-burst flag, expected pulse count or 255 for model only}
   localparam logic [44:0] VEC [NV] = '{
      {36'h0_0000_0000, 1'b0, 8'd1},
      {36'hF_FFFF_FFFF, 1'b0, 8'd255},
      {36'hA_5A5A_5A5A, 1'b1, 8'd255},
      {36'h1_2345_6789, 1'b0, 8'd255},
      {36'h8_0000_0001, 1'b1, 8'd255}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sym_tick = 1'b0;
   logic burst_req = 1'b0;
   logic tx_bit = 1'b0;
   logic force_rx = 1'b0;
   logic [1:0] rx_force = 2'b00;
   logic tx_take, tx_busy, rx_bit, rx_valid, rx_bpv;
   logic [1:0] tx_sym, rx_sym;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic done = 1'b0;

   logic [8:0] bsr = '0;
   logic bneg = 1'b1;

   always #2 clk = ~clk;
   assign rx_sym = force_rx ? rx_force : tx_sym;

   ami_burst_codec uut (
      .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .burst_req(burst_req),
      .tx_bit(tx_bit), .tx_take(tx_take), .tx_busy(tx_busy), .tx_sym(tx_sym),
      .rx_tick(sym_tick), .rx_sym(rx_sym), .rx_bit(rx_bit), .rx_valid(rx_valid),
      .rx_bpv(rx_bpv)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         finish_run();
      end
   end

   // One tick cycle then three quiet cycles; checks R11 hold on quiet cycles.
   task automatic do_tick(input logic req, input logic b, output logic take_seen);
      @(negedge clk);
      sym_tick = 1'b1; burst_req = req; tx_bit = b;
      #1 take_seen = tx_take;
      @(negedge clk);
      sym_tick = 1'b0; burst_req = 1'b0;
   endtask

   task automatic quiet(input logic [1:0] held);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R11 symbol held between ticks", tx_sym, held);
      end
   endtask

   function automatic logic [1:0] pulse(input logic neg);
      return neg ? 2'b10 : 2'b01;
   endfunction

   task automatic run_burst(input logic [NB-1:0] pay, input logic mid_req, input logic [7:0] exp_marks);
      logic take;
      logic [1:0] exp, held, last_prev;
      int marks;
      last_prev = pulse(bneg);
      do_tick(1'b1, 1'b0, take);
      exp = pulse(!bneg); bneg = !bneg;
      check("R3 start mark polarity", tx_sym, exp);
      check("R3 start mark opposes last pulse", (tx_sym != last_prev), 1);
      check("R4 no take on start tick", take, 0);
      marks = 1; held = tx_sym;
      quiet(held);
      for (int k = 1; k <= NB; k++) begin
         logic s;
         do_tick(mid_req && k == 10, pay[NB-k], take);
         s = pay[NB-k] ^ bsr[4] ^ bsr[8];
         bsr = {bsr[7:0], s};
         if (s) begin exp = pulse(!bneg); bneg = !bneg; marks++; end
         else exp = 2'b00;
         check("R4 take on payload tick", take, 1);
         check("R5 R6 payload symbol", tx_sym, exp);
         if (k >= 2) begin
            check("R9 rx valid", rx_valid, 1);
            check("R9 rx bit", rx_bit, pay[NB-k+1]);
         end else check("R9 no bit for start", rx_valid, 0);
         check("R10 no violation in loopback", rx_bpv, 0);
         held = tx_sym;
         quiet(held);
      end
      check("R4 busy drops after last bit", tx_busy, 0);
      do_tick(1'b0, 1'b0, take);
      check("R7 R8 zero after burst", tx_sym, 2'b00);
      check("R4 no take after burst", take, 0);
      check("R9 last rx bit", rx_bit, pay[0]);
      check("R9 last rx valid", rx_valid, 1);
      quiet(2'b00);
      do_tick(1'b0, 1'b0, take);
      check("R9 rx stops after payload", rx_valid, 0);
      quiet(2'b00);
      if (exp_marks != 8'd255) check("R5 pulse count", marks, exp_marks);
   endtask

   task automatic rx_inject(input logic [1:0] s);
      logic t;
      force_rx = 1'b1; rx_force = s;
      do_tick(1'b0, 1'b0, t);
   endtask

   initial begin
      logic t;
      repeat (3) @(negedge clk);
      check("R1 reset symbol", tx_sym, 2'b00);
      check("R1 reset busy", tx_busy, 0);
      check("R1 reset rx valid", rx_valid, 0);
      check("R1 reset rx bpv", rx_bpv, 0);
      rst_n = 1'b1;
      // R7: request on non-tick cycles starts nothing
      @(negedge clk); burst_req = 1'b1;
      @(negedge clk); burst_req = 1'b0;
      check("R7 request without tick ignored", tx_busy, 0);
      do_tick(1'b0, 1'b0, t);
      check("R8 idle tick zero", tx_sym, 2'b00);
      quiet(2'b00);
      for (int v = 0; v < NV; v++) begin
         if (v == 0) check("R1 first start positive", pulse(!bneg), 2'b01);
         run_burst(VEC[v][44:9], VEC[v][8], VEC[v][7:0]);
      end
      // Fresh reset, then receive-side directed cases
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check("R1 reset mid-run symbol", tx_sym, 2'b00);
      rx_inject(2'b01);
      check("R10 no violation on first pulse", rx_bpv, 0);
      rx_inject(2'b01);
      check("R10 repeated positive flagged", rx_bpv, 1);
      check("R9 first descrambled bit", rx_bit, 1);
      rx_inject(2'b11);
      check("R2 code 11 is no pulse", rx_bpv, 0);
      check("R2 code 11 descrambles as zero", rx_bit, 0);
      rx_inject(2'b10);
      check("R10 alternating negative ok", rx_bpv, 0);
      rx_inject(2'b10);
      check("R10 repeated negative flagged", rx_bpv, 1);
      rx_inject(2'b00);
      check("R10 zero symbol no flag", rx_bpv, 0);
      force_rx = 1'b0;
      finish_run();
   end
endmodule